// File: doc/BRIEF.md
# Multi-Source Interrupt Controller

This block merges interrupt requests from four parallel-port groups and from a pair of counter outputs into one host interrupt line. Each group supplies two requests, called A and B. Every port request has its own enable bit. At most one counter feeds the merge at a time: a select bit picks it and a separate bit enables it. A global enable bit gates every source, port and counter alike. The qualified requests are ORed into one combined request.

A host-side 32-bit control/status word sets three things: whether the combined request is sampled as a level or caught on an edge, which polarity counts as active, and whether the host line may be driven. In level mode the status bit tracks the request. In edge mode a rising edge sets a sticky status bit. That bit stays set until software writes a one to the clear bit. The host line is active low. It asserts when the status bit, the local enable and the host enable are all set.

The local side holds two 8-bit registers, chosen by a single select input. They are the per-source enable register and the counter/global control register. Every control and status pin is a plain register-access pin. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_hub`

## Requirements
- R1: During reset, both local registers read 0, the host word reads 32'h0000_1001 (local enable bit 0 = 1, mode bit 12 = 1, every other bit 0), and `host_irq_n` is 1.
- R2: In the source enable register (`lb_sel`=0), bit 2g enables request A of group g and bit 2g+1 enables request B of group g, so `port_req[2g]` is A and `port_req[2g+1]` is B. A port request reaches the combined request only when its enable bit and the global enable are both set.
- R3: In the control register (`lb_sel`=1), bit 2 is the global enable, bit 1 enables the counters and bit 0 selects the counter (1 = `ctr_out[1]`, 0 = `ctr_out[0]`). Only the selected counter can contribute, and only when bits 1 and 2 are both set.
- R4: The source enable register reads back its full written byte. The control register reads back bits 2:0, and its bits 7:3 read 0.
- R5: Host word bits 0 (local enable), 1 (polarity, 1 = active high), 6 (host enable) and 8 (1 = edge mode) are writable. Bit 12 always reads 1. All bits not named in R5 to R8 read 0.
- R6: In level mode, host status bit 2 equals, one clock later, the combined request when polarity is 1, and its inverse when polarity is 0.
- R7: In edge mode, used with polarity 1, a rising edge of the combined request sets status bit 2. The bit then holds until a host write with bit 10 = 1. A rising edge in the same cycle as the clear leaves the bit set.
- R8: In level mode a host write with bit 10 = 1 has no effect on status. Bit 10 always reads 0.
- R9: `host_irq_n` is 0 exactly when host bits 2, 0 and 6 all read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lb_we | input | 1 | Local register write strobe |
| lb_sel | input | 1 | Local register select: 0 source enables, 1 control |
| lb_wdata | input | 8 | Local write data |
| lb_rdata | output | 8 | Local read data of the selected register |
| hs_we | input | 1 | Host word write strobe |
| hs_wdata | input | 32 | Host write data |
| hs_rdata | output | 32 | Host control/status word |
| port_req | input | 8 | Port requests, two per group |
| ctr_out | input | 2 | Counter outputs |
| host_irq_n | output | 1 | Host interrupt, active low |

## Verification
The assertions assume that edge mode is only ever paired with active-high polarity. They also assume that the sticky-status property is judged only when the combined request is low, so that a new edge cannot mask a clear. The random host writes in the stimulus force bit 1 to 1 whenever they set bit 8. The directed edge-mode sequences do the same. The source and counter inputs are otherwise left unconstrained, so every mix of enables, selects and requests is reached.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int LB_W   = 8;
  localparam int HOST_W = 32;
  // host word bit positions (software decodes these)
  localparam int H_LEN  = 0;
  localparam int H_POL  = 1;
  localparam int H_STS  = 2;
  localparam int H_HEN  = 6;
  localparam int H_EDGE = 8;
  localparam int H_CLR  = 10;
  localparam int H_MODE = 12;
  // control register bit positions
  localparam int C_SEL  = 0;
  localparam int C_CEN  = 1;
  localparam int C_GEN  = 2;
  localparam int CTL_W  = 3;

  typedef struct packed {
    logic len;
    logic pol;
    logic hen;
    logic edge_m;
  } host_cfg_t;
endpackage

// File: rtl/irq_lb_regs.sv
module irq_lb_regs
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [LB_W-1:0]  wdata,
  output logic [NSRC-1:0]  src_en,
  output logic [CTL_W-1:0] ctl,
  output logic [LB_W-1:0]  rdata
);
  logic [LB_W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      ctl  <= '0;
    end else if (we) begin
      if (sel) ctl  <= wdata[CTL_W-1:0];
      else     en_q <= wdata;
    end
  end

  assign src_en = en_q[NSRC-1:0];
  assign rdata  = sel ? {{(LB_W-CTL_W){1'b0}}, ctl} : en_q;
endmodule

// File: rtl/irq_src_gate.sv
module irq_src_gate
  import irq_hub_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0]  port_req,
  input  logic [1:0]       ctr_out,
  input  logic [NSRC-1:0]  src_en,
  input  logic [CTL_W-1:0] ctl,
  output logic             req_any
);
  logic [NSRC-1:0] qual;
  logic            ctr_pick;

  for (genvar i = 0; i < NSRC; i++) begin : g_qual
    assign qual[i] = port_req[i] & src_en[i];
  end

  assign ctr_pick = ctl[C_SEL] ? ctr_out[1] : ctr_out[0];
  assign req_any  = ctl[C_GEN] & ((|qual) | (ctl[C_CEN] & ctr_pick));
endmodule

// File: rtl/irq_host_stage.sv
module irq_host_stage
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [HOST_W-1:0] wdata,
  input  logic              req,
  output logic [HOST_W-1:0] rdata,
  output logic              irq_n
);
  host_cfg_t cfg;
  logic      sts_q;
  logic      prev_q;
  logic      line;
  logic      unused_wbits;

  assign unused_wbits = ^{wdata[HOST_W-1:11], wdata[9], wdata[7], wdata[5:2]};
  assign line = cfg.pol ? req : ~req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '{len: 1'b1, pol: 1'b0, hen: 1'b0, edge_m: 1'b0};
      sts_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= line;
      if (we) begin
        cfg.len    <= wdata[H_LEN];
        cfg.pol    <= wdata[H_POL];
        cfg.hen    <= wdata[H_HEN];
        cfg.edge_m <= wdata[H_EDGE];
      end
      if (!cfg.edge_m)               sts_q <= line;
      else if (line && !prev_q)      sts_q <= 1'b1;
      else if (we && wdata[H_CLR])   sts_q <= 1'b0;
    end
  end

  always_comb begin
    rdata         = '0;
    rdata[H_LEN]  = cfg.len;
    rdata[H_POL]  = cfg.pol;
    rdata[H_STS]  = sts_q;
    rdata[H_HEN]  = cfg.hen;
    rdata[H_EDGE] = cfg.edge_m;
    rdata[H_MODE] = 1'b1;
  end

  assign irq_n = ~(sts_q & cfg.len & cfg.hen);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_GROUPS  = 4,
  parameter int REQ_PER_GRP = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                lb_we,
  input  logic                                lb_sel,
  input  logic [LB_W-1:0]                     lb_wdata,
  output logic [LB_W-1:0]                     lb_rdata,
  input  logic                                hs_we,
  input  logic [HOST_W-1:0]                   hs_wdata,
  output logic [HOST_W-1:0]                   hs_rdata,
  input  logic [NUM_GROUPS*REQ_PER_GRP-1:0]   port_req,
  input  logic [1:0]                          ctr_out,
  output logic                                host_irq_n
);
  localparam int NSRC = NUM_GROUPS * REQ_PER_GRP;

  logic [NSRC-1:0]  src_en;
  logic [CTL_W-1:0] ctl;
  logic             comb_req;

  irq_lb_regs #(.NSRC(NSRC)) u_lb (
    .clk(clk), .rst_n(rst_n), .we(lb_we), .sel(lb_sel), .wdata(lb_wdata),
    .src_en(src_en), .ctl(ctl), .rdata(lb_rdata)
  );

  irq_src_gate #(.NSRC(NSRC)) u_gate (
    .port_req(port_req), .ctr_out(ctr_out), .src_en(src_en), .ctl(ctl),
    .req_any(comb_req)
  );

  irq_host_stage u_host (
    .clk(clk), .rst_n(rst_n), .we(hs_we), .wdata(hs_wdata), .req(comb_req),
    .rdata(hs_rdata), .irq_n(host_irq_n)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_we,
  input logic wclr,
  input logic len,
  input logic pol,
  input logic sts,
  input logic hen,
  input logic edge_m,
  input logic comb_req,
  input logic host_irq_n
);
  // R9
  irq_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_n == !(sts && len && hen));

  // R6
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_m |=> sts == $past(pol ? comb_req : !comb_req));

  // R7
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_m && sts && !(hs_we && wclr)) |=> sts);

  // R7
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_m && pol && hs_we && wclr && !comb_req) |=> !sts);

  // R8
  level_clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_m && pol && comb_req && hs_we && wclr) |=> sts);
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_we(hs_we), .wclr(hs_wdata[10]),
  .len(hs_rdata[0]), .pol(hs_rdata[1]), .sts(hs_rdata[2]), .hen(hs_rdata[6]),
  .edge_m(hs_rdata[8]), .comb_req(comb_req), .host_irq_n(host_irq_n)
);

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lb_we = 0, lb_sel = 0, hs_we = 0;
  logic [7:0]  lb_wdata = 0, lb_rdata;
  logic [31:0] hs_wdata = 0, hs_rdata;
  logic [7:0]  port_req = 0;
  logic [1:0]  ctr_out = 0;
  logic        host_irq_n;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_hub u_dut (.*);

  // behavioural reference
  bit [7:0] m_src; bit [2:0] m_ctl;
  bit m_len, m_pol, m_hen, m_edge, m_sts, m_prev;

  always @(posedge clk) begin
    bit req, line;
    if (!rst_n) begin
      m_src = 0; m_ctl = 0; m_len = 1; m_pol = 0; m_hen = 0;
      m_edge = 0; m_sts = 0; m_prev = 0;
    end else begin
      req = 0;
      for (int i = 0; i < 8; i++) if (port_req[i] && m_src[i]) req = 1;
      if (m_ctl[1] && ctr_out[m_ctl[0]]) req = 1;
      if (!m_ctl[2]) req = 0;
      line = m_pol ? req : !req;
      if (!m_edge) m_sts = line;
      else if (line && !m_prev) m_sts = 1;
      else if (hs_we && hs_wdata[10]) m_sts = 0;
      m_prev = line;
      if (hs_we) begin
        m_len = hs_wdata[0]; m_pol = hs_wdata[1];
        m_hen = hs_wdata[6]; m_edge = hs_wdata[8];
      end
      if (lb_we) begin
        if (lb_sel) m_ctl = lb_wdata[2:0]; else m_src = lb_wdata;
      end
    end
  end

  function automatic logic [31:0] exp_host();
    logic [31:0] v = 0;
    v[0] = m_len; v[1] = m_pol; v[2] = m_sts; v[6] = m_hen;
    v[8] = m_edge; v[12] = 1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [7:0] el;
    @(negedge clk);
    if (rst_n) begin
      el = lb_sel ? {5'b0, m_ctl} : m_src;
      chk(lb_rdata === el, "R4 lb_rdata", lb_rdata, el);
      chk(hs_rdata[2] === m_sts, m_edge ? "R7 status" : "R6 status", hs_rdata[2], m_sts);
      chk(hs_rdata === exp_host(), "R5 host word", hs_rdata, exp_host());
      chk(host_irq_n === !(m_sts && m_len && m_hen), "R9 host_irq_n", host_irq_n, !(m_sts && m_len && m_hen));
    end
  endtask

  task automatic lb_wr(input bit s, input logic [7:0] d);
    lb_we = 1; lb_sel = s; lb_wdata = d; tick(); lb_we = 0;
  endtask

  task automatic hs_wr(input logic [31:0] d);
    hs_we = 1; hs_wdata = d; tick(); hs_we = 0; hs_wdata = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    lb_sel = 0; #1;
    chk(lb_rdata === 8'h00, "R1 src reg", lb_rdata, 0);
    lb_sel = 1; #1;
    chk(lb_rdata === 8'h00, "R1 ctl reg", lb_rdata, 0);
    chk(hs_rdata === 32'h1001, "R1 host word", hs_rdata, 32'h1001);
    chk(host_irq_n === 1'b1, "R1 host_irq_n", host_irq_n, 1);
    lb_sel = 0; rst_n = 1; tick();

    // R4 readback with unused control bits
    lb_wr(1, 8'hF8); lb_sel = 1; tick();
    chk(lb_rdata === 8'h00, "R4 ctl high bits", lb_rdata, 0);

    // R2 group 1 request A = bit 2
    hs_wr(32'h0000_0043);          // len, pol=1, hen, level
    lb_wr(0, 8'h04); lb_wr(1, 8'h04);
    port_req = 8'h04; tick(); tick();
    chk(host_irq_n === 1'b0, "R2 enabled A source", host_irq_n, 0);
    port_req = 8'h08; tick(); tick();
    chk(hs_rdata[2] === 1'b0, "R2 disabled B source", hs_rdata[2], 0);
    port_req = 8'h04; lb_wr(1, 8'h00); tick();
    chk(hs_rdata[2] === 1'b0, "R2 global off", hs_rdata[2], 0);
    port_req = 0;

    // R3 counter select
    lb_wr(1, 8'h06); ctr_out = 2'b10; tick(); tick();
    chk(hs_rdata[2] === 1'b0, "R3 counter 2 unselected", hs_rdata[2], 0);
    ctr_out = 2'b01; tick(); tick();
    chk(hs_rdata[2] === 1'b1, "R3 counter 1 selected", hs_rdata[2], 1);
    lb_wr(1, 8'h07); tick();
    chk(hs_rdata[2] === 1'b0, "R3 counter 2 selected, low", hs_rdata[2], 0);
    lb_wr(1, 8'h05); ctr_out = 2'b11; tick(); tick();
    chk(hs_rdata[2] === 1'b0, "R3 counters disabled", hs_rdata[2], 0);

    // R8 clear ignored in level mode
    lb_wr(1, 8'h04); lb_wr(0, 8'h01); port_req = 8'h01; tick();
    hs_wr(32'h0000_0443); tick();
    chk(hs_rdata[2] === 1'b1, "R8 clear in level", hs_rdata[2], 1);
    chk(hs_rdata[10] === 1'b0, "R8 clear reads 0", hs_rdata[10], 0);

    // R7 edge mode sticky and clear
    port_req = 0; hs_wr(32'h0000_0143); tick();
    port_req = 8'h01; tick(); port_req = 0; tick(); tick();
    chk(hs_rdata[2] === 1'b1, "R7 sticky", hs_rdata[2], 1);
    hs_wr(32'h0000_0543); tick();
    chk(hs_rdata[2] === 1'b0, "R7 cleared", hs_rdata[2], 0);
    port_req = 8'h01; hs_wr(32'h0000_0543);
    chk(hs_rdata[2] === 1'b1, "R7 edge beats clear", hs_rdata[2], 1);
    port_req = 0; tick();

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] d;
      port_req = $urandom; ctr_out = $urandom; lb_sel = $urandom;
      if ($urandom_range(0, 9) == 0) lb_wr($urandom, $urandom);
      else if ($urandom_range(0, 9) == 0) begin
        d = $urandom;
        if (d[8]) d[1] = 1;
        hs_wr(d);
      end else tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule